// File: doc/BRIEF.md
# Phased Two-Rail Code Checker

The block watches a word of `NUM_PAIRS` bit pairs that should be two-rail coded: in every pair the second bit is the inverse of the first. It splits the pairs into a lower half and an upper half and gives each half its own sub-checker. The lower sub-checker drives rail `f_o` and the upper one drives rail `g_o`. The block works in two alternating phases, one clock cycle each. In the high phase the upper sub-checker is forced to 1 by a select term, and the lower one reports 1 only if one of its pairs is broken. In the low phase the two halves swap roles. A healthy word therefore makes the rails alternate between the complementary values 01 and 10.

A broken pair, with both bits equal at 0 or at 1, drives its half's rail to 1 in the phase where that rail should be 0, so both rails read 1. The select term moves through the pair positions of each half in turn. This exercises the select path of every pair, and it makes a select that never fires show up as both rails at 0. A registered flag `err_o` records, one cycle later, any cycle in which the two rails were equal.

Top module: `tworail_checker`

## Requirements
- R1: Pair j is broken when x_i[j] equals y_i[j], whether both bits are 0 or both are 1; it is healthy when they differ.
- R2: The phase output starts high (1) after reset and inverts on every clock edge.
- R3: In the high phase sel_o has exactly one bit set, and that bit lies in the upper half (bits NUM_PAIRS/2 and above). In the low phase exactly one bit is set, and it lies in the lower half (bits below NUM_PAIRS/2).
- R4: The select position p starts at 0, holds across a high phase and the low phase after it, then advances by one (wrapping modulo NUM_PAIRS/2). The set bit of sel_o is NUM_PAIRS/2+p in the high phase and p in the low phase.
- R5: With every pair healthy, f_o=0 and g_o=1 in the high phase, and f_o=1 and g_o=0 in the low phase.
- R6: A broken pair in the lower half (bits below NUM_PAIRS/2) gives f_o=g_o=1 in the high phase. A broken pair in the upper half gives f_o=g_o=1 in the low phase. This holds for one or several broken pairs.
- R7: With broken pairs in both halves, f_o=g_o=1 in both phases.
- R8: err_o equals 1 in the cycle after any cycle in which f_o equalled g_o, and 0 otherwise.
- R9: While rst_ni is low: err_o=0, the phase is high and the select position is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one cycle is one checker phase |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | NUM_PAIRS | First bit of each pair |
| y_i | input | NUM_PAIRS | Second bit of each pair |
| f_o | output | 1 | Rail from the lower-half sub-checker |
| g_o | output | 1 | Rail from the upper-half sub-checker |
| phase_o | output | 1 | Current phase, 1 = high |
| sel_o | output | NUM_PAIRS | Select lines, lower half in the low bits |
| err_o | output | 1 | Registered rail-equality flag |

## Verification
A rail can be driven to 1 by two things in the same cycle: the select term of its own phase, and a broken pair in its half. Each input vector is held for a full rotation of the select position. A broken pair therefore sits on, and also off, the selected position, in both phases. The rails are compared each cycle with a model that tracks the phase and position. The model predicts that the off-phase rail rises only because of the broken pairs and that the on-phase rail stays at 1 whatever the select position is. It also checks that the error flag follows one cycle later.

// File: rtl/tworail_pkg.sv
package tworail_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/tworail_sel_ring.sv
module tworail_sel_ring
  import tworail_pkg::*;
#(
  parameter int unsigned HALF = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output phase_e          phase_o,
  output logic [HALF-1:0] ptr_o
);
  localparam logic [HALF-1:0] PTR_RST = HALF'(1);

  phase_e          phase_q;
  logic [HALF-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_HIGH;
      ptr_q   <= PTR_RST;
    end else begin
      phase_q <= (phase_q == PH_HIGH) ? PH_LOW : PH_HIGH;
      // advance after the low phase closes a full period
      if (phase_q == PH_LOW) ptr_q <= {ptr_q[HALF-2:0], ptr_q[HALF-1]};
    end
  end

  assign phase_o = phase_q;
  assign ptr_o   = ptr_q;

  // R2
  phase_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (phase_q != $past(phase_q)));
  // R4
  ptr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ptr_q) == 1);
  // R4
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HIGH) |=> $stable(ptr_q));
endmodule

// File: rtl/tworail_half.sv
module tworail_half #(
  parameter int unsigned HALF = 4
) (
  input  logic [HALF-1:0] x_i,
  input  logic [HALF-1:0] y_i,
  input  logic [HALF-1:0] sel_i,
  output logic            rail_o
);
  logic [HALF-1:0] hit;

  for (genvar j = 0; j < HALF; j++) begin : g_pair
    // equal bits form a path; a select forces one
    assign hit[j] = (x_i[j] ~^ y_i[j]) | sel_i[j];
  end

  assign rail_o = |hit;
endmodule

// File: rtl/tworail_checker.sv
module tworail_checker
  import tworail_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PAIRS-1:0] x_i,
  input  logic [NUM_PAIRS-1:0] y_i,
  output logic                 f_o,
  output logic                 g_o,
  output logic                 phase_o,
  output logic [NUM_PAIRS-1:0] sel_o,
  output logic                 err_o
);
  localparam int unsigned HALF = NUM_PAIRS / 2;

  initial begin
    pairs_param_chk: assert (NUM_PAIRS >= 4 && NUM_PAIRS % 2 == 0)
      else $error("NUM_PAIRS must be even and at least 4");
  end

  phase_e          phase;
  logic [HALF-1:0] ptr;
  logic [HALF-1:0] sel_lo, sel_hi;
  logic            f_rail, g_rail;
  logic            err_q;

  tworail_sel_ring #(.HALF(HALF)) i_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase),
    .ptr_o   (ptr)
  );

  assign sel_hi = (phase == PH_HIGH) ? ptr : '0;
  assign sel_lo = (phase == PH_LOW)  ? ptr : '0;

  tworail_half #(.HALF(HALF)) i_lo (
    .x_i    (x_i[HALF-1:0]),
    .y_i    (y_i[HALF-1:0]),
    .sel_i  (sel_lo),
    .rail_o (f_rail)
  );

  tworail_half #(.HALF(HALF)) i_hi (
    .x_i    (x_i[NUM_PAIRS-1:HALF]),
    .y_i    (y_i[NUM_PAIRS-1:HALF]),
    .sel_i  (sel_hi),
    .rail_o (g_rail)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= (f_rail == g_rail);
  end

  assign f_o     = f_rail;
  assign g_o     = g_rail;
  assign phase_o = (phase == PH_HIGH);
  assign sel_o   = {sel_hi, sel_lo};
  assign err_o   = err_q;

  // R3
  sel_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel_o) == 1);
  // R5
  healthy_rails_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((x_i ^ y_i) == {NUM_PAIRS{1'b1}}) |-> (f_o != g_o));
  // R8
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_o == g_o) |=> err_o);
  // R8
  err_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_o != g_o) |=> !err_o);
endmodule

// File: tb/test_tworail_checker.sv
module test_tworail_checker;
  localparam int unsigned N = 8;
  localparam int unsigned H = N / 2;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 10;

  // x/y stimulus pairs; bit j of x and y form pair j
  localparam logic [N-1:0] VX [NV] = '{8'hFF, 8'h00, 8'hFE, 8'hFF, 8'hEF,
                                       8'hFF, 8'h7E, 8'hF0, 8'h0F, 8'hA5};
  localparam logic [N-1:0] VY [NV] = '{8'h00, 8'hFF, 8'h00, 8'h08, 8'h00,
                                       8'h80, 8'h00, 8'h00, 8'h00, 8'h5A};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] x = '1, y = '0;
  logic         f, g, ph, err;
  logic [N-1:0] sel;

  int checks = 0, errors = 0, cyc = 0;
  logic exp_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tworail_checker #(.NUM_PAIRS(N)) i_tworail_checker (
    .clk_i(clk), .rst_ni(rst_n), .x_i(x), .y_i(y),
    .f_o(f), .g_o(g), .phase_o(ph), .sel_o(sel), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // at a negedge: drive, check cycle cyc, advance to next negedge
  task automatic step(input logic [N-1:0] vx, input logic [N-1:0] vy);
    logic [N-1:0] brk;
    logic lo_b, hi_b, e_ph, e_f, e_g;
    logic [N-1:0] e_sel;
    int p;
    x = vx; y = vy;
    #1;
    brk  = ~(vx ^ vy);                 // R1
    lo_b = |brk[H-1:0];
    hi_b = |brk[N-1:H];
    e_ph = (cyc % 2 == 0);
    p    = (cyc / 2) % H;
    e_sel = e_ph ? (N'(1) << (H + p)) : (N'(1) << p);
    e_f  = lo_b | !e_ph;
    e_g  = hi_b | e_ph;
    chk(ph == e_ph, "R2", "phase", 64'(ph), 64'(e_ph));
    chk(sel == e_sel, "R3/R4", "sel_o", 64'(sel), 64'(e_sel));
    chk(f == e_f, (lo_b && hi_b) ? "R7" : (lo_b ? "R6" : "R5"), "f_o", 64'(f), 64'(e_f));
    chk(g == e_g, (lo_b && hi_b) ? "R7" : (hi_b ? "R6" : "R5"), "g_o", 64'(g), 64'(e_g));
    chk(err == exp_err, "R8", "err_o", 64'(err), 64'(exp_err));
    exp_err = (e_f == e_g);
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R9 reset state
    chk(err == 1'b0, "R9", "err_o in reset", 64'(err), 64'h0);
    chk(ph == 1'b1, "R9", "phase in reset", 64'(ph), 64'h1);
    chk(sel == (N'(1) << H), "R9", "sel_o in reset", 64'(sel), 64'(N'(1) << H));
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0; exp_err = 1'b0;

    // table walk: each vector held over a full select rotation
    for (int v = 0; v < NV; v++)
      for (int k = 0; k < 2 * H; k++) step(VX[v], VY[v]);

    // R1 both-one polarity on every pair, each alone
    for (int j = 0; j < N; j++) begin
      step(N'('1), N'(1) << j);
      step(N'('1), N'(1) << j);
    end
    // R1 both-zero polarity on every pair, each alone
    for (int j = 0; j < N; j++) begin
      step(~(N'(1) << j), N'(0));
      step(~(N'(1) << j), N'(0));
    end

    // R9 mid-run reset: leave err pending, then reset
    step(N'('0), N'(0));
    rst_n = 1'b0;
    #1;
    chk(err == 1'b0, "R9", "err_o after async reset", 64'(err), 64'h0);
    chk(ph == 1'b1, "R9", "phase after async reset", 64'(ph), 64'h1);
    chk(sel == (N'(1) << H), "R9", "sel_o after async reset", 64'(sel), 64'(N'(1) << H));
    @(negedge clk);
    x = '1; y = '0;
    rst_n = 1'b1;
    cyc = 0; exp_err = 1'b0;
    // R4 wrap across several rotations with healthy words
    for (int k = 0; k < 4 * H + 2; k++) step(N'(8'h3C), N'(8'hC3));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule